// File: doc/BRIEF.md
# Tick-Stepped Multi-Channel PWM Generator

This block produces several low-resolution pulse-width-modulated outputs. All of them advance on a shared periodic strobe rather than on every clock. Each channel has three pieces of state: a period counter that counts down the steps of one PWM cycle, a duty register that follows that channel's nibble of a packed setting input, and a duty counter. At every period wrap, the duty register is copied into the duty counter. While that counter is nonzero the output is high, and the counter counts down once per step. A channel with a cycle of C steps therefore offers C+1 output levels, from fully off to fully on.

An optional divider sits between the external strobe and the channels. With a divide ratio of K, the channels step once every K strobes, which stretches the PWM period without touching the cycle constants. Each channel has its own cycle constant, and the channels run independently of each other. A new setting can be written at any time. It takes effect at the channel's next period wrap, so the current cycle always completes cleanly.

Top module: `pwm_multi`

## Requirements
- R1: While `rst_ni` is low, and after reset until a channel's first period wrap, every `pwm_o` bit is 0.
- R2: The period counter of channel k wraps on step number CYCLES[k] after reset and then on every further CYCLES[k] steps.
- R3: On a wrap step with latched duty D (0 < D < C), the output is high on that step and the next D-1 steps, then low for the remaining C-D steps of the cycle.
- R4: A latched duty of 0 keeps the channel's output low for the whole cycle.
- R5: A latched duty of C or more keeps the output high for the whole cycle. With C = 15, a setting of 15 is full on.
- R6: Bits [4k+3:4k] of `duty_set_i` set channel k. Bits 3:0 drive `pwm_o[0]` and bits 7:4 drive `pwm_o[1]`.
- R7: A setting change in the middle of a cycle leaves the output pattern of that cycle unchanged. The new value takes effect at the next wrap.
- R8: Outputs change only on a clock edge at which a channel step occurs. On all other clocks they hold their value, whatever `duty_set_i` does.
- R9: With TICK_DIV = K, a channel step occurs on the K-th, 2K-th, ... strobe counted from reset. Strobes in between leave the outputs and counters unchanged.
- R10: Channels with different cycle constants run independently, each on its own period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock strobe that paces the PWM steps |
| duty_set_i | input | NUM_CH*DUTY_W | Packed duty settings, one nibble per channel |
| pwm_o | output | NUM_CH | PWM outputs |

## Verification
A setting must be present at least one clock before the strobe edge that samples it, because the duty register adds one clock of delay. The outputs change on the same clock edge at which a strobe is sampled as a step. The bench therefore changes the setting on a falling edge several clocks before each strobe. It holds the strobe high across exactly one rising edge, then compares every output at the following falling edge against a value computed from the step count since reset, the cycle constant, and the duty latched at the most recent wrap. Between strobes, the outputs are compared clock by clock against their previous value.

// File: rtl/pwm_tick_pkg.sv
package pwm_tick_pkg;
  localparam int DEF_CNT_W  = 8;
  localparam int DEF_DUTY_W = 4;
  localparam int DEF_NUM_CH = 2;
endpackage

// File: rtl/tick_div.sv
module tick_div #(
  parameter int DIV = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic step_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign step_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assert_cnt_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_step_spacing_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && (DIV > 1)) |=> !step_o);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CYCLE  = 15,
  parameter int CNT_W  = 8,
  parameter int DUTY_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  localparam logic [CNT_W-1:0] CYC = CNT_W'(CYCLE);

  logic [CNT_W-1:0]  period_q;
  logic [DUTY_W-1:0] duty_q, dcnt_q, duty_eff;
  logic              wrap;

  assign wrap = (period_q == CNT_W'(1));

  // duty counter is refreshed from the register only at a wrap
  always_comb duty_eff = wrap ? duty_q : dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) duty_q <= '0;
    else         duty_q <= duty_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= CYC;
      dcnt_q   <= '0;
      pwm_o    <= 1'b0;
    end else if (step_i) begin
      period_q <= wrap ? CYC : period_q - CNT_W'(1);
      if (duty_eff != '0) begin
        pwm_o  <= 1'b1;
        dcnt_q <= duty_eff - DUTY_W'(1);
      end else begin
        pwm_o  <= 1'b0;
        dcnt_q <= '0;
      end
    end
  end

  assert_period_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_q >= CNT_W'(1)) && (period_q <= CYC));
  assert_idle_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pwm_o) && $stable(period_q));
  assert_zero_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wrap && duty_q == '0) |=> !pwm_o);
  assert_full_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wrap && int'(duty_q) >= CYCLE) |=> pwm_o);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_tick_pkg::*;
#(
  parameter int NUM_CH   = DEF_NUM_CH,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int DUTY_W   = DEF_DUTY_W,
  parameter logic [NUM_CH*CNT_W-1:0] CYCLES = {8'd15, 8'd15},
  parameter int TICK_DIV = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [NUM_CH*DUTY_W-1:0] duty_set_i,
  output logic [NUM_CH-1:0]        pwm_o
);
  logic step;

  tick_div #(.DIV(TICK_DIV)) i_tick_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .step_o(step)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int CYC_K = int'(CYCLES[k*CNT_W +: CNT_W]);
    pwm_chan #(.CYCLE(CYC_K), .CNT_W(CNT_W), .DUTY_W(DUTY_W)) i_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step),
      .duty_i(duty_set_i[k*DUTY_W +: DUTY_W]),
      .pwm_o (pwm_o[k])
    );
  end
endmodule

// File: tb/test_pwm_multi.sv
`timescale 1ns/1ps
module test_pwm_multi;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [7:0] duty_set = 8'h00;
  logic [1:0] pwm_a, pwm_b;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int pulses = 0, steps_a = 0, steps_b = 0;
  int lat_a[2] = '{0, 0};
  int lat_b[2] = '{0, 0};
  int cyc_a[2] = '{15, 15};
  int cyc_b[2] = '{10, 6};

  always #2.5 clk = ~clk;

  pwm_multi i_pwm_multi (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .duty_set_i(duty_set), .pwm_o(pwm_a)
  );

  pwm_multi #(.CYCLES({8'd6, 8'd10}), .TICK_DIV(2)) i_pwm_multi_alt (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i),
    .duty_set_i(duty_set), .pwm_o(pwm_b)
  );

  function automatic logic exp_out(int s, int c, int d);
    if (s < c) return 1'b0;
    return ((s - c) % c) < d;
  endfunction

  function automatic int nib(int ch);
    return ch == 0 ? int'(duty_set[3:0]) : int'(duty_set[7:4]);
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s act=%0b exp=%0b", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    for (int ch = 0; ch < 2; ch++) begin
      chk(tag, $sformatf("A ch%0d step%0d", ch, steps_a), pwm_a[ch],
          exp_out(steps_a, cyc_a[ch], lat_a[ch]));
      chk(tag, $sformatf("B ch%0d step%0d", ch, steps_b), pwm_b[ch],
          exp_out(steps_b, cyc_b[ch], lat_b[ch]));
    end
  endtask

  // one strobe, preceded by idle clocks; outputs are checked at the next falling edge
  task automatic tick_once(string tag);
    repeat (2) @(negedge clk);
    tick_i = 1'b1;
    @(posedge clk);
    pulses++;
    steps_a = pulses;
    for (int ch = 0; ch < 2; ch++)
      if (steps_a >= cyc_a[ch] && (steps_a - cyc_a[ch]) % cyc_a[ch] == 0)
        lat_a[ch] = nib(ch);
    if (pulses % 2 == 0) begin
      steps_b++;
      for (int ch = 0; ch < 2; ch++)
        if (steps_b >= cyc_b[ch] && (steps_b - cyc_b[ch]) % cyc_b[ch] == 0)
          lat_b[ch] = nib(ch);
    end
    @(negedge clk);
    tick_i = 1'b0;
    compare_all(tag);
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick_once(tag);
  endtask

  task automatic t_reset_R1;
    chk("R1", "A during reset", pwm_a[0] | pwm_a[1], 1'b0);
    chk("R1", "B during reset", pwm_b[0] | pwm_b[1], 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    duty_set = 8'hFF;
    run(14, "R1");
    run(16, "R5");
  endtask

  task automatic t_levels_R3;
    @(negedge clk) duty_set = 8'h95;
    run(30, "R3");
    @(negedge clk) duty_set = 8'hE1;
    run(30, "R6");
    @(negedge clk) duty_set = 8'h3C;
    run(30, "R10");
  endtask

  task automatic t_zero_R4;
    @(negedge clk) duty_set = 8'h00;
    run(30, "R4");
    @(negedge clk) duty_set = 8'hF0;
    run(30, "R4");
  endtask

  task automatic t_mid_change_R7;
    @(negedge clk) duty_set = 8'h4B;
    run(37, "R7");
    @(negedge clk) duty_set = 8'hA2;
    run(23, "R7");
  endtask

  task automatic t_idle_R8;
    logic [1:0] ha, hb;
    @(negedge clk);
    ha = pwm_a;
    hb = pwm_b;
    for (int i = 0; i < 20; i++) begin
      duty_set = 8'(i * 37 + 5);
      @(negedge clk);
      chk("R8", "A hold", pwm_a[0], ha[0]);
      chk("R8", "A hold", pwm_a[1], ha[1]);
      chk("R8", "B hold", pwm_b[0], hb[0]);
      chk("R8", "B hold", pwm_b[1], hb[1]);
    end
    duty_set = 8'h77;
    run(2, "R8");
  endtask

  task automatic t_div_R9;
    @(negedge clk) duty_set = 8'h37;
    run(41, "R9");
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_R1();
    t_levels_R3();
    t_zero_R4();
    t_mid_change_R7();
    t_idle_R8();
    t_div_R9();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule